// File: doc/BRIEF.md
# Phase-Shifted Eight-Channel PWM Generator

This block drives a bank of PWM outputs, eight by default, from a single shared frame counter that advances once per clock. Each channel has its own high-tick count, low-tick count and tick offset. A channel's period is the sum of its high and low counts. Its phase is the shared count plus its offset, so the channels run shifted against each other while sharing one time base. The outputs are captured in one output register, so every channel switches on the same clock edge.

Generation is gated by a run latch. A one-cycle start pulse sets the latch and a stop pulse clears it. While the latch is clear, every output is held low, including the whole interval from reset to the first start. New channel settings are picked up only at a frame boundary of the shared counter, so a reprogrammed channel never emits a cut-short period in the middle of a frame.

Top module: `pwm_phase_bank`

## Requirements
- R1: While `rst` is high, all `pwm_o` bits are 0 and the run latch is cleared. After `rst` falls, the shared frame count is 0 in the first two cycles and then counts up by one per cycle.
- R2: A cycle with `start_i`=1 and `stop_i`=0 sets the run latch. The latch stays set in later cycles while both pulses are 0.
- R3: A cycle with `stop_i`=1 clears the run latch, even when `start_i` is also 1 in that cycle.
- R4: While the run latch is clear, every `pwm_o` bit is 0.
- R5: Channel n reads high count H from `high_i[n*VAL_W +: VAL_W]`, low count L from `low_i[n*VAL_W +: VAL_W]` and offset O from `offset_i[n*VAL_W +: VAL_W]`, with period P=H+L. Its raw level in a cycle is 1 exactly when (frame count + O) mod P < H.
- R6: `pwm_o` in cycle t+1 equals the raw levels of cycle t ANDed with the run latch of cycle t. All channels update on the same edge.
- R7: With H=0 a channel is always low. With L=0 and H>0 it is always high while running. With H=L=0 it is low.
- R8: An offset O with O >= P is treated as 0.
- R9: H, L and O are sampled only in the first cycle after reset and in the cycle where the frame count equals 2^CNT_W-1. The sampled values apply from the next cycle, and changes at other times have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sets the run latch |
| stop_i | input | 1 | Stop pulse, clears the run latch (dominant) |
| high_i | input | NCH*VAL_W | Per-channel high-tick counts, channel n at bits n*VAL_W |
| low_i | input | NCH*VAL_W | Per-channel low-tick counts |
| offset_i | input | NCH*VAL_W | Per-channel phase offsets in ticks |
| pwm_o | output | NCH | Registered PWM outputs |

## Verification
The embedded assertions check several rules on every cycle: stop dominates start, the latch holds between pulses, outputs are low one cycle after the latch is clear, the counter steps and wraps correctly, each phase register stays below its period, and held settings do not change between frame boundaries. Only the bench's scenarios can show that the waveform itself is right. That includes the position of each edge against the shared count and offset, and the zero-count and oversized-offset corners. It also covers the frame at which reprogrammed values first appear, and the behaviour of outputs across a stop, a restart and a mid-run reset.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DEF_NCH   = 8;
  localparam int unsigned DEF_VAL_W = 8;
  localparam int unsigned DEF_CNT_W = 10;
endpackage

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr #(
  parameter int unsigned CNT_W = pwm_pkg::DEF_CNT_W
) (
  input  logic clk,
  input  logic rst,
  output logic load_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             first_q;

  assign load_o = first_q | (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      if (load_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load_o |=> cnt_q == $past(cnt_q) + 1'b1);
  // R9
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |=> cnt_q == '0);
endmodule

// File: rtl/pwm_run_latch.sv
module pwm_run_latch (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o
);
  always_ff @(posedge clk) begin
    if (rst)          run_o <= 1'b0;
    else if (stop_i)  run_o <= 1'b0;
    else              run_o <= run_o | start_i;
  end

  // R3
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !run_o);
  // R2
  start_set_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> run_o);
  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !stop_i) |=> run_o == $past(run_o));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned VAL_W = pwm_pkg::DEF_VAL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [VAL_W-1:0] high_i,
  input  logic [VAL_W-1:0] low_i,
  input  logic [VAL_W-1:0] off_i,
  output logic             raw_o
);
  localparam int unsigned PW = VAL_W + 1;

  logic [VAL_W-1:0] hi_q, lo_q;
  logic [PW-1:0]    ph_q;
  logic [PW-1:0]    per_q, per_in, ph_inc, off_ext;

  assign per_q   = {1'b0, hi_q} + {1'b0, lo_q};
  assign per_in  = {1'b0, high_i} + {1'b0, low_i};
  assign ph_inc  = ph_q + 1'b1;
  assign off_ext = {1'b0, off_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      ph_q <= '0;
    end else if (load_i) begin
      hi_q <= high_i;
      lo_q <= low_i;
      ph_q <= (off_ext < per_in) ? off_ext : '0;
    end else begin
      ph_q <= (ph_inc >= per_q) ? '0 : ph_inc;
    end
  end

  assign raw_o = (ph_q < {1'b0, hi_q});

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(hi_q) && $stable(lo_q)));
  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q < per_q) || (ph_q == '0));
  // R7
  zero_high_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_q == '0 && !load_i) |=> !raw_o);
endmodule

// File: rtl/pwm_phase_bank.sv
module pwm_phase_bank #(
  parameter int unsigned NCH   = pwm_pkg::DEF_NCH,
  parameter int unsigned VAL_W = pwm_pkg::DEF_VAL_W,
  parameter int unsigned CNT_W = pwm_pkg::DEF_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [NCH*VAL_W-1:0] high_i,
  input  logic [NCH*VAL_W-1:0] low_i,
  input  logic [NCH*VAL_W-1:0] offset_i,
  output logic [NCH-1:0]     pwm_o
);
  logic           load;
  logic           run;
  logic [NCH-1:0] raw;

  pwm_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .load_o(load)
  );

  pwm_run_latch u_run (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .run_o(run)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    pwm_chan #(.VAL_W(VAL_W)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .load_i(load),
      .high_i(high_i[n*VAL_W +: VAL_W]),
      .low_i (low_i[n*VAL_W +: VAL_W]),
      .off_i (offset_i[n*VAL_W +: VAL_W]),
      .raw_o (raw[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= '0;
    else     pwm_o <= raw & {NCH{run}};
  end

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> pwm_o == '0);
endmodule

// File: tb/tb_pwm_phase_bank.sv
module tb_pwm_phase_bank;
  localparam int NCH = 8;
  localparam int VAL_W = 8;
  localparam int CNT_W = 10;
  localparam int FMAX = (1 << CNT_W) - 1;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [VAL_W-1:0] hi_r [NCH];
  logic [VAL_W-1:0] lo_r [NCH];
  logic [VAL_W-1:0] of_r [NCH];
  logic [NCH*VAL_W-1:0] high_i, low_i, offset_i;
  logic [NCH-1:0] pwm_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int n = 0; n < NCH; n++) begin
      high_i[n*VAL_W +: VAL_W]   = hi_r[n];
      low_i[n*VAL_W +: VAL_W]    = lo_r[n];
      offset_i[n*VAL_W +: VAL_W] = of_r[n];
    end

  pwm_phase_bank #(.NCH(NCH), .VAL_W(VAL_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .high_i(high_i), .low_i(low_i), .offset_i(offset_i), .pwm_o(pwm_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model state
  int kc = 0;
  bit run_m = 0, rst_prev = 0;
  logic [NCH-1:0] exp_q = '0;
  string tag_q [NCH];
  int sh [NCH], sl [NCH], so [NCH];

  function automatic bit ref_level(int fc, int h, int l, int o);
    int p, ph;
    p = h + l;
    if (p == 0) return 1'b0;
    ph = (fc + ((o < p) ? o : 0)) % p;
    return ph < h;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      if (rst_prev) chk(pwm_o == '0, "R1", pwm_o, 0);
      rst_prev = 1;
      kc = 0; run_m = 0; exp_q = '0;
      for (int n = 0; n < NCH; n++) begin
        sh[n] = 0; sl[n] = 0; so[n] = 0; tag_q[n] = "R1";
      end
    end else begin
      int fc;
      bit run_nx;
      rst_prev = 0;
      for (int n = 0; n < NCH; n++)
        chk(pwm_o[n] == exp_q[n], tag_q[n], pwm_o[n], exp_q[n]);
      chk(pwm_o == exp_q, "R6", pwm_o, exp_q);
      fc = (kc == 0) ? 0 : (kc - 1) % (FMAX + 1);
      run_nx = stop_i ? 1'b0 : (start_i ? 1'b1 : run_m);
      for (int n = 0; n < NCH; n++) begin
        bit lvl;
        lvl = (kc == 0) ? 1'b0 : ref_level(fc, sh[n], sl[n], so[n]);
        exp_q[n] = run_m & lvl;
        if (kc == 0)                                  tag_q[n] = "R1";
        else if (!run_m)                              tag_q[n] = "R4";
        else if (hi_r[n] != sh[n] || lo_r[n] != sl[n] || of_r[n] != so[n]) tag_q[n] = "R9";
        else if (sh[n] == 0 || sl[n] == 0)            tag_q[n] = "R7";
        else if (so[n] >= sh[n] + sl[n])              tag_q[n] = "R8";
        else                                          tag_q[n] = "R5";
      end
      if (kc == 0 || fc == FMAX)
        for (int n = 0; n < NCH; n++) begin
          sh[n] = hi_r[n]; sl[n] = lo_r[n]; so[n] = of_r[n];
        end
      // R2/R3 checked through the gating seen in the next cycle's outputs
      if (run_nx != run_m)
        for (int n = 0; n < NCH; n++) if (tag_q[n] == "R4" || tag_q[n] == "R5")
          tag_q[n] = run_nx ? "R2" : "R3";
      run_m = run_nx;
      kc++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(bit s, bit p);
    start_i = s; stop_i = p;
    tick(1);
    start_i = 0; stop_i = 0;
  endtask

  task automatic rand_cfg();
    for (int n = 4; n < NCH; n++) begin
      hi_r[n] = VAL_W'($urandom % 40);
      lo_r[n] = VAL_W'($urandom % 40);
      of_r[n] = VAL_W'($urandom % 90);
    end
  endtask

  task automatic directed_cfg();
    hi_r[0] = 0;  lo_r[0] = 7;  of_r[0] = 2;   // R7 high zero
    hi_r[1] = 9;  lo_r[1] = 0;  of_r[1] = 3;   // R7 low zero
    hi_r[2] = 0;  lo_r[2] = 0;  of_r[2] = 5;   // R7 both zero
    hi_r[3] = 5;  lo_r[3] = 6;  of_r[3] = 40;  // R8 oversized offset
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int n = 0; n < NCH; n++) begin hi_r[n] = 0; lo_r[n] = 0; of_r[n] = 0; end
    directed_cfg();
    rand_cfg();
    tick(5);
    rst = 0;
    tick(1500);                 // R4 idle before first start
    pulse(1, 0);                // R2
    tick(1200);
    rand_cfg();                 // R9 mid-frame change
    hi_r[3] = 3; of_r[3] = 1;
    tick(1500);
    for (int r = 0; r < 4; r++) begin
      rand_cfg();
      tick(700);
    end
    pulse(1, 1);                // R3 stop wins
    tick(300);
    pulse(1, 0);
    tick(600);
    pulse(0, 1);                // R3 plain stop
    tick(200);
    pulse(1, 0);
    tick(400);
    rst = 1;                    // R1 mid-run reset
    tick(3);
    rst = 0;
    tick(20);
    pulse(1, 0);
    tick(1200);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule